// File: doc/BRIEF.md
# Count/Link Conditional Branch Resolver

This block settles the outcome of one branch per clock for a RISC core that keeps a loop-count register and a link register. Each request carries the branch address, a decoded branch kind, a 5-bit options field, a 5-bit index into the 32-bit condition register, a displacement, and separate absolute and link flags. From these the block decides whether the branch is taken and which address comes next. It also produces the update for the count register and the update for the link register.

The options field can combine three things: a decrement of the count register, a test of the decremented count for zero or nonzero, and a test of one condition bit for true or false. Together these give nine distinct branch conditions. The link and absolute flags act the same way on every branch kind. All results are registered and appear one clock after the request. The core applies the two register writes itself.

Top module: `branch_resolver`

## Requirements
- R1: `cbit_sel` picks one bit of `cond_reg`. Index 0 is the least significant bit. The picked bit is the tested condition.
- R2: The options bits are decoded as follows. Bit 0 set skips the condition test. With bit 0 clear, the condition must equal bit 1. Bit 4 has no effect.
- R3: On a conditional kind with options bit 2 clear, the count register is decremented (`cnt_we`=1, `cnt_wdata`=`count_reg`-1). The count test uses the decremented value: options bit 3 set requires it to be zero, and bit 3 clear requires it to be nonzero. With bit 2 set there is no decrement and no count test.
- R4: Kind 0 (always) is taken whatever the options are. It never decrements.
- R5: For kinds 0 and 1 (direct), the target is `disp` when `abs_mode`=1. When `abs_mode`=0 the target is `pc`+`disp`, with wraparound.
- R6: Kind 2 takes its target from `link_reg` and kind 3 from `count_reg`. In both cases the low two bits are forced to zero, and `abs_mode` and `disp` are ignored.
- R7: A branch that is not taken gives `res_next_pc` = `pc`+4.
- R8: With `link_mode`=1 the block raises `lnk_we` with `lnk_wdata` = `pc`+4, for every kind and whether or not the branch is taken. With `link_mode`=0, `lnk_we` stays low.
- R9: Kind 3 with options bit 2 clear is illegal. The block raises `res_illegal`, writes no count, and treats the count test as passed. The condition test still applies.
- R10: Results appear one clock after a request with `req_valid`=1. Without a request, and after a synchronous reset, `res_valid`, `res_taken`, `res_illegal`, `cnt_we` and `lnk_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch is presented this cycle |
| req_kind | input | 2 | 0 always, 1 conditional direct, 2 conditional via link, 3 conditional via count |
| opt | input | 5 | Branch options field |
| cbit_sel | input | 5 | Condition-register bit index |
| pc | input | 32 | Address of the branch |
| disp | input | 32 | Sign-extended byte displacement or absolute target |
| abs_mode | input | 1 | Direct target is absolute |
| link_mode | input | 1 | Save the return address |
| cond_reg | input | 32 | Condition register |
| link_reg | input | 32 | Current link register value |
| count_reg | input | 32 | Current count register value |
| res_valid | output | 1 | Result is valid |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 32 | Next fetch address |
| res_illegal | output | 1 | Illegal count-form decrement |
| cnt_we | output | 1 | Count register write enable |
| cnt_wdata | output | 32 | New count value |
| lnk_we | output | 1 | Link register write enable |
| lnk_wdata | output | 32 | New link value |

## Verification
The checker uses `$past` to compare each result against the request that produced it. This assumes that every result comes from the inputs of exactly the previous cycle, and that `pc`, `req_kind`, `link_mode` and `count_reg` are stable when sampled with `req_valid` high. The stimulus meets this by presenting one full request per clock, driven between edges and held until the next one. The sweep covers all four kinds, all 32 option values, both flags and count values that reach zero, that wrap from zero, and that stay large. The selected condition bit changes from vector to vector, so both condition values occur for every option value.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BK_ALWAYS    = 2'b00,
    BK_DIRECT    = 2'b01,
    BK_VIA_LINK  = 2'b10,
    BK_VIA_COUNT = 2'b11
  } br_kind_e;

  localparam int OPT_W       = 5;
  // bit positions inside the options field
  localparam int OPT_NO_COND = 0;
  localparam int OPT_CVAL    = 1;
  localparam int OPT_NO_DEC  = 2;
  localparam int OPT_ON_ZERO = 3;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CR_W  = 32,
  localparam int SEL_W = $clog2(CR_W)
) (
  input  br_kind_e            kind,
  input  logic [3:0]          opt_lo,
  input  logic [SEL_W-1:0]    sel,
  input  logic [CR_W-1:0]     cond_reg,
  input  logic [XLEN-1:0]     count_reg,
  output logic                take,
  output logic                dec_en,
  output logic [XLEN-1:0]     count_next,
  output logic                illegal
);
  logic cbit;
  logic cond_ok;
  logic cnt_zero;
  logic cnt_ok;
  logic wants_dec;

  always_comb begin
    cbit       = cond_reg[sel];
    cond_ok    = opt_lo[OPT_NO_COND] | (cbit == opt_lo[OPT_CVAL]);
    wants_dec  = (kind != BK_ALWAYS) && !opt_lo[OPT_NO_DEC];
    illegal    = wants_dec && (kind == BK_VIA_COUNT);
    dec_en     = wants_dec && !illegal;
    count_next = count_reg - XLEN'(1);
    cnt_zero   = (count_next == '0);
    cnt_ok     = opt_lo[OPT_NO_DEC] | illegal |
                 (opt_lo[OPT_ON_ZERO] ? cnt_zero : !cnt_zero);
    take       = (kind == BK_ALWAYS) | (cnt_ok & cond_ok);
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter int ALIGN_BITS = 2
) (
  input  br_kind_e         kind,
  input  logic             abs_mode,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  disp,
  input  logic [XLEN-1:0]  link_reg,
  input  logic [XLEN-1:0]  count_reg,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  seq_pc
);
  localparam logic [XLEN-1:0] ALIGN_MASK =
    {{(XLEN-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

  logic [XLEN-1:0] direct_tgt;

  always_comb begin
    seq_pc     = pc + XLEN'(INSN_BYTES);
    direct_tgt = abs_mode ? disp : (pc + disp);
    unique case (kind)
      BK_VIA_LINK:  target = link_reg & ALIGN_MASK;
      BK_VIA_COUNT: target = count_reg & ALIGN_MASK;
      default:      target = direct_tgt;
    endcase
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CR_W       = 32,
  parameter int INSN_BYTES = 4,
  parameter int ALIGN_BITS = 2,
  localparam int SEL_W     = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [OPT_W-1:0]  opt,
  input  logic [SEL_W-1:0]  cbit_sel,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   disp,
  input  logic              abs_mode,
  input  logic              link_mode,
  input  logic [CR_W-1:0]   cond_reg,
  input  logic [XLEN-1:0]   link_reg,
  input  logic [XLEN-1:0]   count_reg,
  output logic              res_valid,
  output logic              res_taken,
  output logic [XLEN-1:0]   res_next_pc,
  output logic              res_illegal,
  output logic              cnt_we,
  output logic [XLEN-1:0]   cnt_wdata,
  output logic              lnk_we,
  output logic [XLEN-1:0]   lnk_wdata
);
  br_kind_e        kind;
  logic            take;
  logic            dec_en;
  logic            illegal;
  logic [XLEN-1:0] count_next;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] seq_pc;
  logic            unused_opt_hi;

  assign kind          = br_kind_e'(req_kind);
  assign unused_opt_hi = opt[OPT_W-1];

  br_cond_eval #(.XLEN(XLEN), .CR_W(CR_W)) u_cond (
    .kind       (kind),
    .opt_lo     (opt[3:0]),
    .sel        (cbit_sel),
    .cond_reg   (cond_reg),
    .count_reg  (count_reg),
    .take       (take),
    .dec_en     (dec_en),
    .count_next (count_next),
    .illegal    (illegal)
  );

  br_target_gen #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .ALIGN_BITS(ALIGN_BITS)) u_tgt (
    .kind      (kind),
    .abs_mode  (abs_mode),
    .pc        (pc),
    .disp      (disp),
    .link_reg  (link_reg),
    .count_reg (count_reg),
    .target    (target),
    .seq_pc    (seq_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
      res_illegal <= 1'b0;
      cnt_we      <= 1'b0;
      cnt_wdata   <= '0;
      lnk_we      <= 1'b0;
      lnk_wdata   <= '0;
    end else begin
      res_valid   <= req_valid;
      res_taken   <= req_valid & take;
      res_next_pc <= take ? target : seq_pc;
      res_illegal <= req_valid & illegal;
      cnt_we      <= req_valid & dec_en;
      cnt_wdata   <= count_next;
      lnk_we      <= req_valid & link_mode;
      lnk_wdata   <= seq_pc;
    end
  end
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter int ALIGN_BITS = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      req_kind,
  input logic [XLEN-1:0] pc,
  input logic            link_mode,
  input logic [XLEN-1:0] count_reg,
  input logic            res_valid,
  input logic            res_taken,
  input logic [XLEN-1:0] res_next_pc,
  input logic            res_illegal,
  input logic            cnt_we,
  input logic [XLEN-1:0] cnt_wdata,
  input logic            lnk_we,
  input logic [XLEN-1:0] lnk_wdata
);
  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken) |-> res_next_pc == $past(pc) + XLEN'(INSN_BYTES));

  assert_link_enable_R8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> lnk_we == $past(link_mode));

  assert_link_value_R8: assert property (@(posedge clk) disable iff (rst)
    lnk_we |-> lnk_wdata == $past(pc) + XLEN'(INSN_BYTES));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_we |-> cnt_wdata == $past(count_reg) - XLEN'(1));

  assert_illegal_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> !cnt_we);

  assert_always_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(req_kind) == 2'b00) |-> (res_taken && !cnt_we));

  assert_reg_target_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken && $past(req_kind[1])) |-> res_next_pc[ALIGN_BITS-1:0] == '0);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!cnt_we && !lnk_we && !res_illegal && !res_taken));
endmodule

bind branch_resolver br_resolver_chk #(
  .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .ALIGN_BITS(ALIGN_BITS)
) u_chk (
  .clk(clk), .rst(rst), .req_kind(req_kind), .pc(pc), .link_mode(link_mode),
  .count_reg(count_reg), .res_valid(res_valid), .res_taken(res_taken),
  .res_next_pc(res_next_pc), .res_illegal(res_illegal), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .lnk_we(lnk_we), .lnk_wdata(lnk_wdata)
);

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [4:0]  opt;
  logic [4:0]  cbit_sel;
  logic [31:0] pc, disp, cond_reg, link_reg, count_reg;
  logic        abs_mode, link_mode;
  logic        res_valid, res_taken, res_illegal, cnt_we, lnk_we;
  logic [31:0] res_next_pc, cnt_wdata, lnk_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .opt(opt),
    .cbit_sel(cbit_sel), .pc(pc), .disp(disp), .abs_mode(abs_mode),
    .link_mode(link_mode), .cond_reg(cond_reg), .link_reg(link_reg),
    .count_reg(count_reg), .res_valid(res_valid), .res_taken(res_taken),
    .res_next_pc(res_next_pc), .res_illegal(res_illegal), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .lnk_we(lnk_we), .lnk_wdata(lnk_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h (kind=%0d opt=%b abs=%b lnk=%b cnt=%h)",
               tag, act, exp, req_kind, opt, abs_mode, link_mode, count_reg);
    end
  endtask

  function automatic logic [31:0] cnt_pick(input int c);
    case (c)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h0000_0002;
      default: return 32'h0000_8006;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog R10 act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    bit e_cond_ok, e_illegal, e_dec, e_cnt_ok, e_taken;
    logic [31:0] e_newc, e_tgt, e_next;
    rst = 1'b1; req_valid = 1'b0; req_kind = '0; opt = '0; cbit_sel = '0;
    pc = 32'h0000_4000; disp = '0; abs_mode = 1'b0; link_mode = 1'b1;
    cond_reg = 32'h9C3A_5B61; link_reg = 32'h0001_2347; count_reg = 32'h1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!res_valid && !res_taken && !cnt_we && !lnk_we && !res_illegal, "R10 reset",
        {27'd0, res_valid, res_taken, cnt_we, lnk_we, res_illegal}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R10: no request means no writes even with link_mode set
    chk(!res_valid && !lnk_we && !cnt_we, "R10 idle",
        {29'd0, res_valid, lnk_we, cnt_we}, 32'h0);

    idx = 0;
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 32; o++)
        for (int c = 0; c < 4; c++)
          for (int a = 0; a < 2; a++)
            for (int l = 0; l < 2; l++) begin
              req_valid = 1'b1;
              req_kind  = 2'(k);
              opt       = 5'(o);
              cbit_sel  = 5'((idx * 11 + o) % 32);
              pc        = 32'h0000_4000 + 32'(idx * 4);
              disp      = idx[0] ? 32'hFFFF_FF00 : 32'h0000_0140;
              abs_mode  = a[0];
              link_mode = l[0];
              count_reg = cnt_pick(c);
              // expected model
              e_cond_ok = opt[0] | (cond_reg[cbit_sel] == opt[1]);        // R1 R2
              e_illegal = (k == 3) && !opt[2];                            // R9
              e_dec     = (k != 0) && !opt[2] && !e_illegal;              // R3
              e_newc    = count_reg - 32'd1;
              e_cnt_ok  = opt[2] | e_illegal | (opt[3] ? (e_newc == 0) : (e_newc != 0));
              e_taken   = (k == 0) | (e_cnt_ok & e_cond_ok);              // R4
              if (k == 2)      e_tgt = link_reg & 32'hFFFF_FFFC;          // R6
              else if (k == 3) e_tgt = count_reg & 32'hFFFF_FFFC;
              else             e_tgt = abs_mode ? disp : pc + disp;       // R5
              e_next = e_taken ? e_tgt : pc + 32'd4;                      // R7
              @(negedge clk);
              chk(res_valid, "R10 valid", {31'd0, res_valid}, 32'd1);
              chk(res_taken == e_taken, (k == 0) ? "R4 taken" : "R1/R2/R3 taken",
                  {31'd0, res_taken}, {31'd0, e_taken});
              chk(res_next_pc == e_next, k[1] ? "R6 next" : (e_taken ? "R5 next" : "R7 next"),
                  res_next_pc, e_next);
              chk(res_illegal == e_illegal, "R9 illegal", {31'd0, res_illegal}, {31'd0, e_illegal});
              chk(cnt_we == e_dec, "R3 cnt_we", {31'd0, cnt_we}, {31'd0, e_dec});
              if (e_dec) chk(cnt_wdata == e_newc, "R3 cnt_wdata", cnt_wdata, e_newc);
              chk(lnk_we == link_mode, "R8 lnk_we", {31'd0, lnk_we}, {31'd0, link_mode});
              if (link_mode) chk(lnk_wdata == pc + 32'd4, "R8 lnk_wdata", lnk_wdata, pc + 32'd4);
              idx++;
            end

    req_valid = 1'b0;
    @(negedge clk);
    chk(!res_valid && !cnt_we && !lnk_we && !res_illegal, "R10 drain",
        {28'd0, res_valid, cnt_we, lnk_we, res_illegal}, 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule